// File: doc/BRIEF.md
# I2C Bus-Hang Recovery Sequencer

This block sits between an I2C master controller and the open-drain SCL/SDA pads. A slave can lose count of SCL edges and keep holding SDA low after the master has finished with a STOP. The STOP is then never seen and the bus stays busy. When the sequencer is kicked, or when the controller reports a hung bus in the first cycle after reset, it holds the controller disabled and takes over both pad output-enables. It releases both lines, then clocks SCL by hand while leaving SDA floating. The stuck slave shifts out the rest of its byte and reads a NACK in the acknowledge slot.

The pulse loop stops as soon as SDA is seen high at the end of a released-SCL phase. The block then drives a START (SDA low while SCL is high) and a STOP (SDA released), hands the pads back and enables the controller. If SDA is still low after the last permitted pulse, it gives up without a START/STOP and reports a failure. Every phase lasts a fixed number of clock cycles. A released-SCL phase counts only the cycles in which SCL reads high, so a slave that stretches the clock lengthens that phase. Software should retry the interrupted transfer once `done` is seen, because the first access after recovery may still fail.

States: IDLE (controller owns the pads). RELEASE (both lines floated for one phase). SCL_LOW (SCL driven low for one phase). SCL_HIGH (SCL released; the phase counts only while SCL reads high). START (SDA driven low for one phase). STOP (SDA released for one phase). HANDBACK (one cycle, controller owns the pads again).

Transitions: IDLE→RELEASE on kick, or on bus_hung in the first cycle after reset. RELEASE→SCL_LOW at phase end. SCL_LOW→SCL_HIGH at phase end. At the end of SCL_HIGH: →START if SDA reads high; otherwise →HANDBACK with failure if PULSES pulses have been made; otherwise →SCL_LOW. START→STOP at phase end. STOP→HANDBACK at phase end. HANDBACK→IDLE always.

Top module: `i2c_bus_unjam`

## Requirements
- R1: While rst_n is low (sampled at a clock edge), the block is in IDLE: ctl_en=1, done=0, fail=0, and scl_oe/sda_oe follow ctl_scl_oe/ctl_sda_oe.
- R2: In IDLE, scl_oe equals ctl_scl_oe and sda_oe equals ctl_sda_oe in the same cycle, and ctl_en=1.
- R3: A recovery starts on kick=1 in IDLE, or on bus_hung=1 in the first cycle after reset only. In the cycle after the trigger, ctl_en=0, scl_oe=0, sda_oe=0, done=0 and fail=0. bus_hung at any later time starts nothing.
- R4: Every SCL low phase (scl_oe=1 while ctl_en=0) lasts exactly PHASE_CYCLES cycles.
- R5: A released-SCL phase between two pulses lasts PHASE_CYCLES cycles plus the number of cycles scl_in is held low by another device after release.
- R6: During the pulse loop sda_oe stays 0. The block never drives SDA and SCL low in the same cycle while it owns the pads.
- R7: The pulse loop ends at the first released-SCL phase whose last cycle sees sda_in=1. A slave that releases SDA after N rising SCL edges (1≤N≤PULSES) gets exactly N pulses. A bus with SDA already high gets one pulse.
- R8: If sda_in is still 0 at the end of the PULSES-th released phase, the block hands back with done=1 and fail=1 and drives no START/STOP (sda_oe never 1).
- R9: On success, sda_oe is 1 for exactly PHASE_CYCLES cycles while SCL is released (START). It is then 0 for PHASE_CYCLES cycles while the block still owns the pads (STOP). Then ctl_en=1, done=1 and fail=0 in the same cycle.
- R10: kick while a recovery is in progress is ignored: the run is not restarted or lengthened, and no second run follows.
- R11: done and fail keep their values after handback until the next recovery starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick | input | 1 | Request a recovery (taken only in IDLE) |
| bus_hung | input | 1 | Controller status: bus busy, or transfer-complete flag clear |
| ctl_scl_oe | input | 1 | Controller request to pull SCL low |
| ctl_sda_oe | input | 1 | Controller request to pull SDA low |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pad enable pulling SCL low |
| sda_oe | output | 1 | Pad enable pulling SDA low |
| ctl_en | output | 1 | Controller enable (0 while recovering) |
| done | output | 1 | Last recovery finished (held) |
| fail | output | 1 | Last recovery gave up with SDA low (held) |

## Verification
The assertions assume that ctl_en low always means the block owns the pads. They also assume scl_in and sda_in are already synchronous to clk, so a line level read in a phase's last cycle is the one the state decision uses. The bench models the open-drain wires as wired-AND. A slave releases SDA after a chosen number of rising SCL edges, and a stretcher holds SCL low for a chosen number of cycles after each release. The controller's own enables are held at 0 during recovery runs, so no spurious rising edge reaches the slave model. Random runs draw the slave's remaining bit count and the stretch length from bounded ranges. Directed runs cover the reset-time trigger, the give-up case, and kicks arriving mid-run.

// File: rtl/unjam_pkg.sv
package unjam_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_SCL_LOW,
        ST_SCL_HIGH,
        ST_START,
        ST_STOP,
        ST_HANDBACK
    } unjam_state_e;

endpackage

// File: rtl/unjam_phase_timer.sv
// Down-counter that marks the last cycle of each timed phase and reloads itself.
module unjam_phase_timer #(
    parameter int unsigned PHASE_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [W-1:0] RELOAD = W'(PHASE_CYCLES - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= RELOAD;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
        end
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/unjam_pulse_counter.sv
// Counts completed SCL low phases within one recovery run.
module unjam_pulse_counter #(
    parameter int unsigned PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int W = $clog2(PULSES + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == W'(PULSES));

endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam
    import unjam_pkg::*;
#(
    parameter int unsigned PHASE_CYCLES = 200000,
    parameter int unsigned PULSES       = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic bus_hung,
    input  logic ctl_scl_oe,
    input  logic ctl_sda_oe,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic ctl_en,
    output logic done,
    output logic fail
);
    unjam_state_e state_q, state_d;
    logic boot_q, done_q, fail_q;
    logic tick, timer_run, timer_clear;
    logic pulse_step, pulse_last;
    logic give_up;
    logic owned;

    unjam_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .run   (timer_run),
        .tick  (tick)
    );

    unjam_pulse_counter #(.PULSES(PULSES)) u_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .step  (pulse_step),
        .last  (pulse_last)
    );

    // Next-state and phase control
    always_comb begin
        state_d     = state_q;
        give_up     = 1'b0;
        timer_clear = (state_q == ST_IDLE);
        timer_run   = 1'b0;
        pulse_step  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (kick || (boot_q && bus_hung)) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                timer_run = 1'b1;
                if (tick) state_d = ST_SCL_LOW;
            end
            ST_SCL_LOW: begin
                timer_run  = 1'b1;
                pulse_step = tick;
                if (tick) state_d = ST_SCL_HIGH;
            end
            ST_SCL_HIGH: begin
                timer_run = scl_in;
                if (tick) begin
                    if (sda_in) begin
                        state_d = ST_START;
                    end else if (pulse_last) begin
                        state_d = ST_HANDBACK;
                        give_up = 1'b1;
                    end else begin
                        state_d = ST_SCL_LOW;
                    end
                end
            end
            ST_START: begin
                timer_run = 1'b1;
                if (tick) state_d = ST_STOP;
            end
            ST_STOP: begin
                timer_run = 1'b1;
                if (tick) state_d = ST_HANDBACK;
            end
            ST_HANDBACK: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and held result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            boot_q  <= 1'b1;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            boot_q  <= 1'b0;
            if (state_q == ST_IDLE && state_d != ST_IDLE) begin
                done_q <= 1'b0;
                fail_q <= 1'b0;
            end
            if (state_q != ST_HANDBACK && state_d == ST_HANDBACK) done_q <= 1'b1;
            if (give_up) fail_q <= 1'b1;
        end
    end

    // Pad and status outputs
    always_comb begin
        owned  = (state_q != ST_IDLE) && (state_q != ST_HANDBACK);
        ctl_en = !owned;
        scl_oe = owned ? (state_q == ST_SCL_LOW) : ctl_scl_oe;
        sda_oe = owned ? (state_q == ST_START)   : ctl_sda_oe;
        done   = done_q;
        fail   = fail_q;
    end

endmodule

// File: rtl/i2c_bus_unjam_chk.sv
module i2c_bus_unjam_chk #(
    parameter int unsigned PHASE_CYCLES = 200000
) (
    input logic clk,
    input logic rst_n,
    input logic ctl_scl_oe,
    input logic ctl_sda_oe,
    input logic scl_oe,
    input logic sda_oe,
    input logic ctl_en,
    input logic done,
    input logic fail
);
    logic [31:0] low_len;

    always_ff @(posedge clk) begin
        if (!rst_n || ctl_en || !scl_oe) low_len <= '0;
        else                             low_len <= low_len + 1'b1;
    end

    // R2
    idle_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_en |-> (scl_oe == ctl_scl_oe) && (sda_oe == ctl_sda_oe));

    // R3
    entry_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_en) |-> !scl_oe && !sda_oe && !done && !fail);

    // R4
    low_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && $past(!ctl_en) && $fell(scl_oe)) |-> (low_len == 32'(PHASE_CYCLES)));

    // R6
    no_double_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && sda_oe) |-> !scl_oe);

    // R8
    fail_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R9
    done_at_handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ctl_en);

    // R11
    done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctl_en) |=> (done || !ctl_en));

endmodule

bind i2c_bus_unjam i2c_bus_unjam_chk #(.PHASE_CYCLES(PHASE_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_scl_oe (ctl_scl_oe),
    .ctl_sda_oe (ctl_sda_oe),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .ctl_en     (ctl_en),
    .done       (done),
    .fail       (fail)
);

// File: tb/i2c_bus_unjam_bench.sv
`timescale 1ns/1ps
module i2c_bus_unjam_bench;
    localparam int P  = 6;
    localparam int NP = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0, bus_hung = 1'b0;
    logic ctl_scl_oe = 1'b0, ctl_sda_oe = 1'b0;
    logic scl_oe, sda_oe, ctl_en, done, fail;
    logic scl_line, sda_line;

    int vectors = 0, errors = 0;

    // bus model state
    int st_cnt = 0, cur_stretch = 0;
    int slave_bits = 0, slave_n = 0;
    logic arm = 1'b0, scl_prev = 1'b1;

    assign scl_line = !scl_oe && (st_cnt == 0);
    assign sda_line = !sda_oe && (slave_bits == 0);

    i2c_bus_unjam #(.PHASE_CYCLES(P), .PULSES(NP)) u_i2c_bus_unjam (
        .clk(clk), .rst_n(rst_n), .kick(kick), .bus_hung(bus_hung),
        .ctl_scl_oe(ctl_scl_oe), .ctl_sda_oe(ctl_sda_oe),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .ctl_en(ctl_en), .done(done), .fail(fail)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (scl_oe) st_cnt <= cur_stretch;
        else if (st_cnt > 0) st_cnt <= st_cnt - 1;
        scl_prev <= scl_line;
        if (arm) slave_bits <= slave_n;
        else if (scl_line && !scl_prev && slave_bits > 0) slave_bits <= slave_bits - 1;
    end

    // run monitor
    int runs = 0, pulses = 0, low_len = 0, gap_len = 0, bad_low = 0, bad_gap = 0;
    int sda_pulses = 0, sda_len = 0, stop_len = 0, sda_bad = 0;
    logic prev_en = 1'b1, prev_scl = 1'b0, prev_sda = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !ctl_en) begin
            if (prev_en) begin
                runs++; pulses = 0; low_len = 0; gap_len = 0; bad_low = 0; bad_gap = 0;
                sda_pulses = 0; sda_len = 0; stop_len = 0; sda_bad = 0;
            end
            if (scl_oe) begin
                if (!prev_scl && pulses > 0 && gap_len != P + cur_stretch) bad_gap++;
                low_len++;
            end else begin
                if (low_len != 0) begin
                    if (low_len != P) bad_low++;
                    pulses++; low_len = 0; gap_len = 0;
                end
                gap_len++;
            end
            if (sda_oe) begin
                if (!prev_sda) sda_pulses++;
                if (!scl_line || scl_oe) sda_bad++;
                sda_len++;
            end else if (sda_pulses > 0) begin
                stop_len++;
            end
            if (sda_oe && pulses < 1) sda_bad++;
        end
        prev_en  = rst_n ? ctl_en : 1'b1;
        prev_scl = scl_oe;
        prev_sda = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int n);
        if (n == 0) return 1;
        if (n > NP) return NP;
        return n;
    endfunction

    function automatic bit exp_fail(input int n);
        return n > NP;
    endfunction

    task automatic await_end(input int n, input int runs_before);
        int lim;
        lim = 0;
        while (!(ctl_en && done) && lim < 5000) begin @(negedge clk); lim++; end
        chk(lim < 5000, "R3 run finished", lim, 0);
        chk(runs == runs_before + 1, "R10 single run", runs, runs_before + 1);
        chk(bad_low == 0, "R4 low phase length", bad_low, 0);
        chk(bad_gap == 0, "R5 released phase length", bad_gap, 0);
        chk(sda_bad == 0, "R6 SDA quiet during pulses", sda_bad, 0);
        chk(pulses == exp_pulses(n), "R7 pulse count", pulses, exp_pulses(n));
        chk(fail == exp_fail(n), "R8 fail flag", int'(fail), int'(exp_fail(n)));
        if (exp_fail(n)) begin
            chk(sda_pulses == 0, "R8 no START on give-up", sda_pulses, 0);
        end else begin
            chk(sda_pulses == 1 && sda_len == P, "R9 START length", sda_len, P);
            chk(stop_len == P, "R9 STOP length", stop_len, P);
        end
    endtask

    task automatic do_run(input int n, input int s, input bit extra_kick);
        int rb;
        rb = runs;
        cur_stretch = s; slave_n = n; arm = 1'b1;
        @(negedge clk); arm = 1'b0; kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        #1 chk(!ctl_en && !scl_oe && !sda_oe && !done && !fail, "R3 entry state", int'(ctl_en), 0);
        if (extra_kick) begin
            repeat (10) @(negedge clk);
            kick = 1'b1; @(negedge clk); kick = 1'b0;
        end
        await_end(n, rb);
    endtask

    initial begin
        #700000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0ffee5));
        ctl_scl_oe = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ctl_en && !done && !fail && scl_oe && !sda_oe, "R1 reset state", int'(ctl_en), 1);
        ctl_scl_oe = 1'b0;
        cur_stretch = 1; slave_n = 3; arm = 1'b1;
        @(negedge clk); arm = 1'b0;
        @(negedge clk);
        // R3 boot-time trigger from bus_hung
        bus_hung = 1'b1; rst_n = 1'b1;
        begin
            int rb;
            rb = runs;
            @(negedge clk);
            await_end(3, rb);
        end
        // R11 results held
        repeat (15) @(negedge clk);
        chk(done && !fail, "R11 done held", int'(done), 1);

        // R3 bus_hung after boot starts nothing
        begin
            int rb;
            rb = runs;
            repeat (20) @(negedge clk);
            chk(runs == rb && ctl_en, "R3 late bus_hung ignored", runs, rb);
            bus_hung = 1'b0;
        end

        // R2 passthrough in idle
        for (int i = 0; i < 8; i++) begin
            ctl_scl_oe = 1'($urandom_range(0, 1));
            ctl_sda_oe = 1'($urandom_range(0, 1));
            #1 chk(scl_oe == ctl_scl_oe && sda_oe == ctl_sda_oe && ctl_en, "R2 passthrough",
                   int'({scl_oe, sda_oe}), int'({ctl_scl_oe, ctl_sda_oe}));
            @(negedge clk);
        end
        ctl_scl_oe = 1'b0; ctl_sda_oe = 1'b0;
        repeat (3) @(negedge clk);

        // directed corners
        do_run(0, 0, 1'b0);     // R7 SDA already high
        do_run(9, 2, 1'b0);     // R7 needs all pulses
        do_run(12, 0, 1'b0);    // R8 give up
        repeat (12) @(negedge clk);
        chk(done && fail, "R11 fail held", int'(fail), 1);
        do_run(4, 3, 1'b1);     // R10 kick mid-run
        chk(!fail, "R11 fail cleared by new run", int'(fail), 0);

        // random runs
        for (int i = 0; i < 24; i++) begin
            do_run(int'($urandom_range(0, 11)), int'($urandom_range(0, 3)),
                   ($urandom_range(0, 3) == 0));
            repeat (int'($urandom_range(1, 5))) @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule